// File: doc/BRIEF.md
# Complementable One-Hot Test Pattern Sequencer

This block produces the logic-level drive patterns for a three-terminal device test socket. A prescaler divides the system clock down to a slow step rate, which is about 45 Hz with the default divider on a 50 MHz clock. On each step a phase counter advances through 0, 1 and 2 and then wraps. The phase is decoded to a one-hot pattern. A select input chooses whether that pattern is driven as it is (one terminal high) or with every bit inverted (one terminal low).

A controller samples its sense lines once per phase, using the phase index, and gathers a full result on the end-of-cycle pulse. The select input is taken up only at a phase boundary. Each phase therefore shows one whole pattern of one set, whenever the select input changes.

Top module: `tps_sequencer`

## Requirements
- R1: While rst_ni is low, and until the first phase step after it goes high, phase_o is 0, pattern_o is 3'b001 (normal set), and cycle_done_o is 0, whatever sel_inv_i is.
- R2: Each phase lasts exactly CLK_DIV clock cycles. After reset is released, phase 0 covers the first CLK_DIV rising edges.
- R3: phase_o steps 0, 1, 2, 0, ... and never shows 3.
- R4: With the normal set in effect, pattern_o has bit k high and the other bits low, where k is phase_o: 001, 010, 100.
- R5: With the inverted set in effect (sel_inv_i = 1 when it is taken up), pattern_o is the bitwise complement of the normal pattern: 110, 101, 011.
- R6: sel_inv_i is sampled only on the clock edge that starts a new phase. A change in the middle of a phase leaves pattern_o unchanged until the next phase starts.
- R7: cycle_done_o is high for exactly one clock cycle: the first cycle of phase 0 after phase 2 ends. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_inv_i | input | 1 | 1 selects the inverted pattern set; taken up at phase boundaries |
| pattern_o | output | PAT_W | Socket drive pattern |
| phase_o | output | $clog2(PAT_W) | Current phase index |
| cycle_done_o | output | 1 | One-cycle pulse at the start of each new cycle |

## Verification
The bench uses a divider of 4 and tracks the expected phase, pattern and set from the number of edges counted since reset. It checks every cycle.

The select input is changed in the middle of a phase and on edges next to a phase boundary. A design that takes the select up at once would show a mixed or early pattern. A design that samples it one edge late would miss a boundary.

The wrap from phase 2 is checked in several ways:
- A counter that reached 3 would drive an all-zero or all-one pattern.
- A late or stretched done pulse would land outside the first cycle of phase 0.
- A prescaler that is off by one would shift every later phase edge.

A reset taken in the middle of a run, with the inverted set selected, must return the block to phase 0 with the normal pattern.

// File: rtl/tps_pkg.sv
package tps_pkg;
  function automatic int unsigned ctr_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int unsigned CW = tps_pkg::ctr_width(CLK_DIV);
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/tps_phase_ctr.sv
module tps_phase_ctr #(
  parameter int unsigned PAT_W = 3,
  localparam int unsigned PH_W = tps_pkg::ctr_width(PAT_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PAT_W - 1);

  logic [PH_W-1:0] phase_q;
  logic            wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= step_i && (phase_q == LAST);
      if (step_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

  p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST);
  p_phase_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));
  p_phase_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == LAST) |=> phase_q == '0);
endmodule

// File: rtl/tps_pattern.sv
module tps_pattern #(
  parameter int unsigned PAT_W = 3,
  localparam int unsigned PH_W = tps_pkg::ctr_width(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             sel_inv_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [PAT_W-1:0] pattern_o
);
  logic inv_q;

  // set selection is taken up only where a new phase begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inv_q <= 1'b0;
    else if (step_i) inv_q <= sel_inv_i;
  end

  for (genvar k = 0; k < PAT_W; k++) begin : g_bit
    assign pattern_o[k] = (phase_i == PH_W'(k)) ^ inv_q;
  end

  p_inv_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(inv_q));
endmodule

// File: rtl/tps_sequencer.sv
module tps_sequencer #(
  parameter int unsigned CLK_DIV = 1111111,
  parameter int unsigned PAT_W   = 3,
  localparam int unsigned PH_W   = tps_pkg::ctr_width(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_inv_i,
  output logic [PAT_W-1:0] pattern_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             cycle_done_o
);
  logic step;

  tps_prescaler #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_o(step)
  );

  tps_phase_ctr #(.PAT_W(PAT_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .phase_o(phase_o), .wrap_o(cycle_done_o)
  );

  tps_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .sel_inv_i(sel_inv_i),
    .phase_i(phase_o), .pattern_o(pattern_o)
  );

  p_pattern_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pattern_o) == 1 || $countones(pattern_o) == PAT_W - 1);
  p_done_in_phase0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |-> phase_o == '0);
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |=> !cycle_done_o);
endmodule

// File: tb/tb_tps_sequencer.sv
module tb_tps_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel = 1'b0;
  logic [2:0] pattern;
  logic [1:0] phase;
  logic done;

  int checks = 0, errors = 0, n = 0;
  logic exp_inv = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tps_sequencer #(.CLK_DIV(DIV), .PAT_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_inv_i(sel),
    .pattern_o(pattern), .phase_o(phase), .cycle_done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, n);
    end
  endtask

  task automatic check_now();
    int ph = (n / DIV) % 3;
    logic [2:0] ep = 3'(1 << ph) ^ (exp_inv ? 3'b111 : 3'b000);
    chk("R2/R3 phase", int'(phase), ph);
    if (sel != exp_inv) chk("R6 pattern held", int'(pattern), int'(ep));
    else if (exp_inv)   chk("R5 pattern", int'(pattern), int'(ep));
    else                chk("R4 pattern", int'(pattern), int'(ep));
    chk("R7 done", int'(done), (n > 0 && n % (3*DIV) == 0) ? 1 : 0);
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    if (n % DIV == 0) exp_inv = sel;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    sel = 1'b1;
    #(3*CLK_PERIOD + 2);
    // R1: reset state ignores select
    chk("R1 phase", int'(phase), 0);
    chk("R1 pattern", int'(pattern), 1);
    chk("R1 done", int'(done), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    sel = 1'b0;
    n = 0; exp_inv = 1'b0;
    check_now();
    for (int i = 0; i < 3*DIV*2; i++) step();          // normal set, R4
    for (int i = 0; i < DIV/2; i++) step();
    sel = 1'b1;                                          // mid-phase change, R6
    for (int i = 0; i < 3*DIV*2; i++) step();           // inverted set, R5
    sel = 1'b0;
    for (int i = 0; i < 3*DIV; i++) step();
    for (int i = 0; i < 120; i++) begin                 // irregular select toggling
      sel = ((i * 7) % 5) < 2;
      step();
    end
    // R1: reset in mid-run with inverted set active
    sel = 1'b1;
    for (int i = 0; i < DIV*2 + 1; i++) step();
    rst_ni = 1'b0;
    #1;
    chk("R1 phase", int'(phase), 0);
    chk("R1 pattern", int'(pattern), 1);
    chk("R1 done", int'(done), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    n = 0; exp_inv = 1'b0;
    check_now();
    for (int i = 0; i < DIV - 1; i++) step();           // R1: normal until first step
    for (int i = 0; i < 3*DIV*2; i++) step();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule